// File: doc/BRIEF.md
# Prioritised Interrupt Controller with Claim and Complete

This block collects interrupt requests from a parameterised set of level-sensitive sources and presents one interrupt line to a single processor target. Software gives each source a small priority and an enable bit. It also sets one threshold, which holds back every request whose priority is not above it. When the line is raised, software reads the claim register. That read returns the number of the most urgent eligible source and takes the source out of the pending set. Once the handler has dealt with the cause at the source, software writes the same number back to the same address to finish the interrupt.

Each source passes through a gateway stage. The gateway latches the request as pending and then refuses further requests from that source while its interrupt is in flight. If the source still holds its request at completion, it becomes pending again on the next clock. A handler that does not clear the cause at the source therefore sees an endless series of interrupts. Source number 0 is reserved: it stands for "nothing to claim" and never takes part in arbitration.

All registers are 32-bit words at byte addresses. Accesses whose two lowest address bits are not zero are ignored.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every priority, every enable bit and the threshold read as 0, no source is pending, `irq_out` is low and a claim read returns 0.
- R2: The priority of source n is held in the low 3 bits of the word at byte address 4*n and reads back as written, with the upper bits dropped. The word for source 0 always reads 0.
- R3: The enable bit of source n is bit (n mod 32) of the word at byte address 0x2000 + 4*(n/32). Bit 0 of the first word always reads 0.
- R4: A source whose request is high and which is not in flight becomes pending at the next clock edge. It stays pending after its request drops, until it is claimed.
- R5: `irq_out` is high exactly when some source is pending, enabled and has a priority strictly greater than the threshold. A disabled source keeps its pending state and raises `irq_out` once it is enabled again.
- R6: The threshold is a 3-bit field at byte address 0x200000 that reads back as written. A threshold of 7 holds back every source, and a source whose priority equals the threshold is held back too.
- R7: A read of byte address 0x200004 returns the eligible source with the highest priority, and the lower source number wins when priorities are equal. The read returns 0 when no source is eligible.
- R8: A claim read that returns source n clears its pending state. Until n is completed, no request from n is accepted, and a pulse on its request in that time is lost.
- R9: Writing n to byte address 0x200004 while n is in flight completes it. If the request of n is still high, n is pending again one clock after the completion.
- R10: A completion write whose value names no source in flight (a source not claimed, or a value of 32 or more) changes no state.
- R11: A request on source 0 never makes anything pending, never raises `irq_out` and never shows in a claim read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released in step with the clock |
| src_req | input | NUM_SRC | Level-sensitive request of each source; bit 0 is reserved |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; a read of the claim address claims the winner at the clock edge |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle as the strobe |
| irq_out | output | 1 | Interrupt request to the target |

## Verification
The bench builds the block with its defaults: 32 sources, 3-bit priorities and a 22-bit byte address. With these values one enable word holds all sources, so the highest source number (31) and the topmost enable bit are both exercised. Both threshold extremes can be set, and equal-priority ties can occur between sources far apart, such as 6 and 13. The priority pattern assigned to the sources gives every level from 1 to 7 several times. This lets table vectors exercise strict-greater masking against the threshold and the rule that the lower source number wins a tie.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // Register map, byte addresses (word aligned)
  localparam logic [31:0] PIC_PRIO_BASE  = 32'h0000_0000;
  localparam logic [31:0] PIC_EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] PIC_THR_ADDR   = 32'h0020_0000;
  localparam logic [31:0] PIC_CLAIM_ADDR = 32'h0020_0004;
  localparam int unsigned PIC_BITS_PER_WORD = 32;
endpackage

// File: rtl/pic_regs.sv
module pic_regs
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ADDR_W  = 22
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [31:0]                     wdata,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_o,
  output logic [NUM_SRC-1:0]              en_o,
  output logic [PRIO_W-1:0]               thr_o,
  output logic                            claim_hit_o,
  output logic [31:0]                     rdata_o
);
  localparam int unsigned ID_W     = $clog2(NUM_SRC);
  localparam int unsigned EN_WORDS = (NUM_SRC + PIC_BITS_PER_WORD - 1) / PIC_BITS_PER_WORD;

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NUM_SRC-1:0]             en_q, en_d;
  logic [PRIO_W-1:0]              thr_q, thr_d;

  logic [31:0]     word_a;
  logic [31:0]     en_widx;
  logic            aligned;
  logic            prio_hit, en_hit, thr_hit, claim_hit;
  logic [ID_W-1:0] prio_idx;

  // Address decode
  always_comb begin
    word_a    = 32'(addr[ADDR_W-1:2]);
    aligned   = (addr[1:0] == 2'b00);
    prio_hit  = aligned && (word_a < 32'(NUM_SRC));
    prio_idx  = word_a[ID_W-1:0];
    en_widx   = word_a - (PIC_EN_BASE >> 2);
    en_hit    = aligned && (word_a >= (PIC_EN_BASE >> 2)) && (en_widx < 32'(EN_WORDS));
    thr_hit   = aligned && (word_a == (PIC_THR_ADDR >> 2));
    claim_hit = aligned && (word_a == (PIC_CLAIM_ADDR >> 2));
  end

  // Next state
  always_comb begin
    prio_d = prio_q;
    en_d   = en_q;
    thr_d  = thr_q;
    if (prio_hit && (prio_idx != '0))
      prio_d[prio_idx] = wdata[PRIO_W-1:0];
    if (en_hit) begin
      for (int i = 1; i < int'(NUM_SRC); i++) begin
        if (en_widx == 32'(i / PIC_BITS_PER_WORD))
          en_d[i] = wdata[i % PIC_BITS_PER_WORD];
      end
    end
    if (thr_hit)
      thr_d = wdata[PRIO_W-1:0];
  end

  // Registers, written only on a bus write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr_en) begin
      prio_q <= prio_d;
      en_q   <= en_d;
      thr_q  <= thr_d;
    end
  end

  // Read data for everything except the claim register
  always_comb begin
    rdata_o = '0;
    if (prio_hit) begin
      rdata_o[PRIO_W-1:0] = prio_q[prio_idx];
    end else if (en_hit) begin
      for (int i = 0; i < int'(NUM_SRC); i++) begin
        if (en_widx == 32'(i / PIC_BITS_PER_WORD))
          rdata_o[i % PIC_BITS_PER_WORD] = en_q[i];
      end
    end else if (thr_hit) begin
      rdata_o[PRIO_W-1:0] = thr_q;
    end
  end

  assign prio_o      = prio_q;
  assign en_o        = en_q;
  assign thr_o       = thr_q;
  assign claim_hit_o = claim_hit;
endmodule

// File: rtl/pic_gateway.sv
module pic_gateway #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ID_W    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               claim_fire,
  input  logic [ID_W-1:0]    claim_id,
  input  logic               cmpl_fire,
  input  logic [ID_W-1:0]    cmpl_id,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] infl_o
);
  // Slot 0 is reserved: no state, never pending
  assign pend_o[0] = 1'b0;
  assign infl_o[0] = 1'b0;

  for (genvar g = 1; g < NUM_SRC; g++) begin : g_slot
    logic pend_q, pend_d;
    logic infl_q, infl_d;
    logic take, clr, done;

    always_comb begin
      take   = req[g] && !pend_q && !infl_q;
      clr    = claim_fire && (claim_id == ID_W'(g));
      done   = cmpl_fire && (cmpl_id == ID_W'(g)) && infl_q;
      pend_d = clr ? 1'b0 : (pend_q | take);
      infl_d = clr ? 1'b1 : (done ? 1'b0 : infl_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        infl_q <= 1'b0;
      end else begin
        pend_q <= pend_d;
        infl_q <= infl_d;
      end
    end

    assign pend_o[g] = pend_q;
    assign infl_o[g] = infl_q;
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = 5
) (
  input  logic [NUM_SRC-1:0]             pend,
  input  logic [NUM_SRC-1:0]             en,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]              thr,
  output logic [ID_W-1:0]                claim_id,
  output logic                           irq
);
  logic [PRIO_W-1:0] best_prio;
  logic [ID_W-1:0]   best_id;

  // Ascending scan with strict compare: an equal priority never displaces
  // an earlier (lower numbered) winner.
  always_comb begin
    best_prio = '0;
    best_id   = '0;
    for (int i = 1; i < int'(NUM_SRC); i++) begin
      if (pend[i] && en[i] && (prio[i] > best_prio)) begin
        best_prio = prio[i];
        best_id   = ID_W'(i);
      end
    end
    irq      = (best_prio > thr);
    claim_id = irq ? best_id : '0;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ADDR_W  = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  input  logic               bus_rd,
  output logic [31:0]        bus_rdata,
  output logic               irq_out
);
  localparam int unsigned ID_W = $clog2(NUM_SRC);

  // Reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [NUM_SRC-1:0]             en;
  logic [NUM_SRC-1:0]             pend;
  logic [NUM_SRC-1:0]             infl;
  logic [PRIO_W-1:0]              thr;
  logic                           claim_hit;
  logic [31:0]                    reg_rdata;
  logic [ID_W-1:0]                claim_id;
  logic [ID_W-1:0]                cmpl_id;
  logic                           claim_fire;
  logic                           cmpl_fire;
  logic                           irq;

  pic_regs #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (bus_wr),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .prio_o      (prio),
    .en_o        (en),
    .thr_o       (thr),
    .claim_hit_o (claim_hit),
    .rdata_o     (reg_rdata)
  );

  pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
    .pend     (pend),
    .en       (en),
    .prio     (prio),
    .thr      (thr),
    .claim_id (claim_id),
    .irq      (irq)
  );

  // Claim on a read of the claim word that names a real source;
  // completion on a write whose value fits a source number.
  assign claim_fire = bus_rd && claim_hit && (claim_id != '0);
  assign cmpl_id    = bus_wdata[ID_W-1:0];
  assign cmpl_fire  = bus_wr && claim_hit && (bus_wdata[31:ID_W] == '0);

  pic_gateway #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_gw (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req        (src_req),
    .claim_fire (claim_fire),
    .claim_id   (claim_id),
    .cmpl_fire  (cmpl_fire),
    .cmpl_id    (cmpl_id),
    .pend_o     (pend),
    .infl_o     (infl)
  );

  assign bus_rdata = claim_hit ? 32'(claim_id) : reg_rdata;
  assign irq_out   = irq;
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ID_W    = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic [PRIO_W-1:0]  thr,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] infl,
  input logic               claim_fire,
  input logic [ID_W-1:0]    claim_id,
  input logic               cmpl_fire,
  input logic [ID_W-1:0]    cmpl_id,
  input logic               bus_rd,
  input logic               claim_hit,
  input logic [31:0]        bus_rdata
);
  // R6: the all-ones threshold lets nothing through
  assert_thr_masks_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (thr != {PRIO_W{1'b1}}));

  // R8: a claimed source leaves the pending set and is in flight
  assert_claim_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    claim_fire |=> (!pend[$past(claim_id)] && infl[$past(claim_id)]));

  // R8: a source is never pending and in flight at once
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & infl) == '0);

  // R10: completing a source not in flight changes no in-flight state
  assert_stray_complete_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_fire && !claim_fire && !infl[cmpl_id]) |=> $stable(infl));

  // R7: a nonzero claim value only appears while the interrupt is raised
  assert_claim_needs_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && claim_hit && (bus_rdata != '0)) |-> irq);
endmodule

bind prio_irq_ctrl pic_checker #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .irq        (irq_out),
  .thr        (thr),
  .pend       (pend),
  .infl       (infl),
  .claim_fire (claim_fire),
  .claim_id   (claim_id),
  .cmpl_fire  (cmpl_fire),
  .cmpl_id    (cmpl_id),
  .bus_rd     (bus_rd),
  .claim_hit  (claim_hit),
  .bus_rdata  (bus_rdata)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC  = 32;
  localparam int AW    = 22;
  localparam logic [AW-1:0] A_EN    = 22'h00_2000;
  localparam logic [AW-1:0] A_THR   = 22'h20_0000;
  localparam logic [AW-1:0] A_CLAIM = 22'h20_0004;

  // Source n is given priority (n mod 7) + 1.
  // Vector: {request pattern, threshold, expected claim}
  localparam int NVEC = 10;
  localparam logic [47:0] VEC [NVEC] = '{
    {32'h0000_0002, 8'd0, 8'd1},   // single source
    {32'h0000_0006, 8'd0, 8'd2},   // higher priority wins
    {32'h0000_2040, 8'd0, 8'd6},   // tie 7/7: lower number wins
    {32'h8000_0080, 8'd0, 8'd31},  // top source
    {32'h0000_0080, 8'd1, 8'd0},   // priority equals threshold (R6)
    {32'h0000_0100, 8'd1, 8'd8},   // one above threshold
    {32'h0010_4000, 8'd6, 8'd20},  // only the 7 passes threshold 6
    {32'h0010_0000, 8'd7, 8'd0},   // threshold 7 masks all (R6)
    {32'h0000_0001, 8'd0, 8'd0},   // reserved source (R11)
    {32'h0800_0400, 8'd3, 8'd27}
  };

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] src_req;
  logic [AW-1:0]   bus_addr;
  logic            bus_wr;
  logic [31:0]     bus_wdata;
  logic            bus_rd;
  logic [31:0]     bus_rdata;
  logic            irq_out;

  int n_chk;
  int n_fail;
  bit done;

  prio_irq_ctrl #(.NUM_SRC(NSRC), .PRIO_W(3), .ADDR_W(AW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd   = 1'b0;
  endtask

  // Claim and complete until nothing is left
  task automatic drain();
    logic [31:0] d;
    bus_write(A_THR, 32'd0);
    for (int k = 0; k < 40; k++) begin
      bus_read(A_CLAIM, d);
      if (d == 32'd0) break;
      bus_write(A_CLAIM, d);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; src_req = '0; bus_addr = '0;
    bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    check(irq_out == 1'b0, "R1 irq after reset", irq_out, 0);
    bus_read(A_THR, d);          check(d == 0, "R1 threshold", d, 0);
    bus_read(22'h24, d);         check(d == 0, "R1 priority 9", d, 0);
    bus_read(A_EN, d);           check(d == 0, "R1 enable word", d, 0);
    bus_read(A_CLAIM, d);        check(d == 0, "R1 claim empty", d, 0);

    // R2: field width and reserved slot
    bus_write(22'h0C, 32'hFF);
    bus_read(22'h0C, d);         check(d == 7, "R2 priority 3 truncated", d, 7);
    bus_write(22'h00, 32'd5);
    bus_read(22'h00, d);         check(d == 0, "R2 priority 0 reserved", d, 0);

    for (int i = 1; i < NSRC; i++) bus_write(AW'(4 * i), 32'((i % 7) + 1));
    bus_read(22'h34, d);         check(d == 7, "R2 priority 13", d, 7);

    // R3: enable word, bit 0 reserved
    bus_write(A_EN, 32'hFFFF_FFFF);
    bus_read(A_EN, d);           check(d == 32'hFFFF_FFFE, "R3 enable readback", d, 32'hFFFF_FFFE);

    // R6: threshold readback
    bus_write(A_THR, 32'd7);
    bus_read(A_THR, d);          check(d == 7, "R6 threshold readback", d, 7);

    // Table of request patterns
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] rq;
      logic [7:0]  th;
      logic [7:0]  ex;
      {rq, th, ex} = VEC[v];
      bus_write(A_THR, 32'(th));
      src_req = rq;
      idle(2);
      check(irq_out == (ex != 0), $sformatf("R5 vec%0d irq", v), irq_out, ex != 0);
      bus_read(A_CLAIM, d);
      check(d == 32'(ex), $sformatf("R7 vec%0d claim", v), d, ex);
      src_req = '0;
      if (ex != 0) bus_write(A_CLAIM, 32'(ex));
      drain();
      idle(1);
      check(irq_out == 1'b0, $sformatf("R9 vec%0d drained", v), irq_out, 0);
    end

    // R11: reserved source request
    src_req[0] = 1'b1;
    idle(3);
    check(irq_out == 1'b0, "R11 source 0 irq", irq_out, 0);
    bus_read(A_CLAIM, d);        check(d == 0, "R11 source 0 claim", d, 0);
    src_req = '0;

    // R4: a one-cycle pulse is held as pending
    src_req[5] = 1'b1;
    idle(1);
    src_req[5] = 1'b0;
    idle(2);
    check(irq_out == 1'b1, "R4 pulse latched", irq_out, 1);
    bus_read(A_CLAIM, d);        check(d == 5, "R4 claim 5", d, 5);

    // R8: pulse while in flight is lost
    check(irq_out == 1'b0, "R8 irq after claim", irq_out, 0);
    src_req[5] = 1'b1;
    idle(1);
    src_req[5] = 1'b0;
    idle(1);
    check(irq_out == 1'b0, "R8 in flight ignores request", irq_out, 0);
    bus_write(A_CLAIM, 32'd5);
    idle(2);
    check(irq_out == 1'b0, "R8 pulse lost", irq_out, 0);
    bus_read(A_CLAIM, d);        check(d == 0, "R8 nothing pending", d, 0);

    // R9: held request re-pends after completion
    src_req[3] = 1'b1;
    idle(2);
    bus_read(A_CLAIM, d);        check(d == 3, "R9 claim 3", d, 3);
    idle(1);
    check(irq_out == 1'b0, "R9 no irq while in flight", irq_out, 0);
    bus_write(A_CLAIM, 32'd3);
    idle(1);
    check(irq_out == 1'b1, "R9 request again", irq_out, 1);
    bus_read(A_CLAIM, d);        check(d == 3, "R9 claim 3 again", d, 3);

    // R10: stray completions ignored
    bus_write(A_CLAIM, 32'd4);
    idle(2);
    check(irq_out == 1'b0, "R10 completion of 4 ignored", irq_out, 0);
    bus_write(A_CLAIM, 32'd35);
    idle(2);
    check(irq_out == 1'b0, "R10 out of range ignored", irq_out, 0);
    bus_write(A_CLAIM, 32'd3);
    idle(1);
    check(irq_out == 1'b1, "R10 real completion", irq_out, 1);
    src_req = '0;
    drain();

    // R5: disabled source keeps pending state
    bus_write(A_EN, 32'hFFFF_FFBF);
    src_req[6] = 1'b1;
    idle(2);
    src_req = '0;
    check(irq_out == 1'b0, "R5 disabled source", irq_out, 0);
    bus_read(A_CLAIM, d);        check(d == 0, "R5 disabled claim", d, 0);
    bus_write(A_EN, 32'hFFFF_FFFF);
    idle(1);
    check(irq_out == 1'b1, "R5 enabled again", irq_out, 1);
    bus_read(A_CLAIM, d);        check(d == 6, "R5 claim 6", d, 6);
    bus_write(A_CLAIM, 32'd6);
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule